// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Banking

This block sits next to a 32-pin GPIO port and turns the port's polarity-corrected input levels and per-pin edge events into interrupt summaries for up to four processors. Each processor owns an edge cause copy, an edge enable mask and a level enable mask. It can therefore enable and acknowledge its own interrupts without disturbing the others, while the level source (the input vector) stays shared by all of them.

A layout parameter selects one of three register arrangements. The global-only arrangement has a single cause/mask set. The dual arrangement adds a second pair of masks for CPU1 beside the shared cause. The quad arrangement adds a separate per-CPU register window that holds four full sets. The shared global set always exists and drives its own group summary. The pending vector of each processor is reduced to one summary line per group of eight pins.

Top module: `gpio_cpu_irq_bank`

## Requirements
- R1: In the quad layout, the per-CPU window (window select 1) decodes CPU n's edge cause at byte offset 4*n, its edge mask at 0x10+4*n and its level mask at 0x20+4*n, for n = 0..3. Each location reads back what was written.
- R2: In the dual layout, CPU0 uses edge mask 0x18 and level mask 0x1C, and CPU1 uses edge mask 0x30 and level mask 0x34, all in window 0. Both CPUs share the edge cause at 0x14. The per-CPU window is not decoded.
- R3: In the global-only layout, only 0x14, 0x18 and 0x1C in window 0 are decoded, and every per-CPU summary line stays 0.
- R4: A CPU's pending vector is (input level AND its level mask) OR (its edge cause AND its edge mask). Summary bit n*4+g of `cpu_irq` is the OR of pending pins 8g..8g+7 of CPU n.
- R5: A write to an edge cause register clears each bit written as 0 and keeps each bit written as 1.
- R6: An edge event sets its bit, on the next clock, in the global cause and in every per-CPU cause copy. Acknowledging one copy leaves all the other copies unchanged.
- R7: When an edge event and an acknowledge that clears the same bit fall in the same cycle, the bit is set afterwards.
- R8: Addresses that are not decoded read as 0 and ignore writes.
- R9: After reset every cause and mask reads 0 and every summary line is 0.
- R10: `glob_irq` is the 4-group summary of the global set: cause 0x14 with edge mask 0x18, and level mask 0x1C with the input level. It is present in every layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Polarity-corrected input level per pin |
| edge_evt | input | 32 | One-cycle edge event per pin |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 1 | Write window: 0 global, 1 per-CPU |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_win | input | 1 | Read window: 0 global, 1 per-CPU |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from the read address |
| glob_irq | output | 4 | Group summaries of the global set |
| cpu_irq | output | 16 | Group summaries, 4 per CPU, CPU n at bits 4n+3..4n |

## Verification
The edge event that sets a cause bit and the acknowledge write that clears it can land in the same clock. The bench provokes this by raising an edge event on one pin in the very cycle that a CPU's cause is written all zero. It then reads that copy back and expects only the new event bit to survive. It also expects a neighbouring copy to hold its full accumulated history. The scoreboard compares the read data against values worked out from the event and write history.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   typedef enum int unsigned {
      LAYOUT_GLOBAL = 0,
      LAYOUT_DUAL   = 1,
      LAYOUT_QUAD   = 2
   } layout_e;

   localparam int MAX_CPUS   = 4;
   localparam int GROUP_PINS = 8;

   // window 0 (global) offsets
   localparam int OFS_G_CAUSE  = 'h14;
   localparam int OFS_G_EMASK  = 'h18;
   localparam int OFS_G_LMASK  = 'h1C;
   localparam int OFS_D_EMASK1 = 'h30;
   localparam int OFS_D_LMASK1 = 'h34;
   // window 1 (per-CPU) bases, stride 4 per CPU
   localparam int OFS_P_CAUSE  = 'h00;
   localparam int OFS_P_EMASK  = 'h10;
   localparam int OFS_P_LMASK  = 'h20;
   localparam int CPU_STRIDE   = 4;
endpackage

// File: rtl/pcb_mask_reg.sv
module pcb_mask_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/pcb_cause_reg.sv
module pcb_cause_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ack_en,
   input  logic [W-1:0] ack_data,
   input  logic [W-1:0] evt,
   output logic [W-1:0] q
);
   logic [W-1:0] kept;

   // a zero bit in the ack data clears, a one keeps; new events always win
   assign kept = ack_en ? (q & ack_data) : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= kept | evt;
   end

   // R6 R7
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((q & $past(evt)) == $past(evt)));

   // R5
   ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_en |=> ((q & $past(q & ack_data)) == $past(q & ack_data)));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_en && evt == '0) |=> $stable(q));
endmodule

// File: rtl/pcb_summary.sv
module pcb_summary #(
   parameter int W  = 32,
   parameter int GP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      data_in,
   input  logic [W-1:0]      lmask,
   input  logic [W-1:0]      cause,
   input  logic [W-1:0]      emask,
   output logic [W/GP-1:0]   grp
);
   localparam int G = W / GP;

   logic [W-1:0] pend;
   assign pend = (data_in & lmask) | (cause & emask);

   for (genvar g = 0; g < G; g++) begin : g_grp
      assign grp[g] = |pend[g*GP +: GP];
   end

   // R4
   grp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp != '0) |-> (((data_in & lmask) != '0) || ((cause & emask) != '0)));
endmodule

// File: rtl/gpio_cpu_irq_bank.sv
module gpio_cpu_irq_bank
   import pcb_pkg::*;
#(
   parameter layout_e LAYOUT   = LAYOUT_QUAD,
   parameter int      NUM_PINS = 32,
   parameter int      ADDR_W   = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PINS-1:0]              data_in,
   input  logic [NUM_PINS-1:0]              edge_evt,
   input  logic                             wr_en,
   input  logic                             wr_win,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [NUM_PINS-1:0]              wr_data,
   input  logic                             rd_win,
   input  logic [ADDR_W-1:0]                rd_addr,
   output logic [NUM_PINS-1:0]              rd_data,
   output logic [NUM_PINS/GROUP_PINS-1:0]   glob_irq,
   output logic [MAX_CPUS*(NUM_PINS/GROUP_PINS)-1:0] cpu_irq
);
   localparam int GROUPS = NUM_PINS / GROUP_PINS;

   if (NUM_PINS % GROUP_PINS != 0 || NUM_PINS < GROUP_PINS || NUM_PINS > 32) begin : g_bad_pins
      $error("NUM_PINS must be a multiple of 8 between 8 and 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must hold offsets up to 0x3C");
   end

   function automatic logic hit(input logic win, input logic [ADDR_W-1:0] a,
                                input logic want_win, input int ofs);
      return (win == want_win) && (a == ADDR_W'(ofs));
   endfunction

   // ---------------- global set (all layouts) ----------------
   logic [NUM_PINS-1:0] g_cause, g_emask, g_lmask;

   pcb_cause_reg #(.W(NUM_PINS)) u_g_cause (
      .clk(clk), .rst_n(rst_n),
      .ack_en(wr_en && hit(wr_win, wr_addr, 1'b0, OFS_G_CAUSE)),
      .ack_data(wr_data), .evt(edge_evt), .q(g_cause));

   pcb_mask_reg #(.W(NUM_PINS)) u_g_emask (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && hit(wr_win, wr_addr, 1'b0, OFS_G_EMASK)),
      .d(wr_data), .q(g_emask));

   pcb_mask_reg #(.W(NUM_PINS)) u_g_lmask (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && hit(wr_win, wr_addr, 1'b0, OFS_G_LMASK)),
      .d(wr_data), .q(g_lmask));

   pcb_summary #(.W(NUM_PINS), .GP(GROUP_PINS)) u_g_sum (
      .clk(clk), .rst_n(rst_n), .data_in(data_in),
      .lmask(g_lmask), .cause(g_cause), .emask(g_emask), .grp(glob_irq));

   // ---------------- dual layout: second mask pair ----------------
   logic [NUM_PINS-1:0] d_emask1, d_lmask1;

   if (LAYOUT == LAYOUT_DUAL) begin : g_dual
      pcb_mask_reg #(.W(NUM_PINS)) u_d_emask1 (
         .clk(clk), .rst_n(rst_n),
         .we(wr_en && hit(wr_win, wr_addr, 1'b0, OFS_D_EMASK1)),
         .d(wr_data), .q(d_emask1));
      pcb_mask_reg #(.W(NUM_PINS)) u_d_lmask1 (
         .clk(clk), .rst_n(rst_n),
         .we(wr_en && hit(wr_win, wr_addr, 1'b0, OFS_D_LMASK1)),
         .d(wr_data), .q(d_lmask1));
   end else begin : g_no_dual
      assign d_emask1 = '0;
      assign d_lmask1 = '0;
   end

   // ---------------- quad layout: per-CPU window ----------------
   logic [NUM_PINS-1:0] p_cause [MAX_CPUS];
   logic [NUM_PINS-1:0] p_emask [MAX_CPUS];
   logic [NUM_PINS-1:0] p_lmask [MAX_CPUS];

   for (genvar c = 0; c < MAX_CPUS; c++) begin : g_pcpu
      if (LAYOUT == LAYOUT_QUAD) begin : g_on
         pcb_cause_reg #(.W(NUM_PINS)) u_cause (
            .clk(clk), .rst_n(rst_n),
            .ack_en(wr_en && hit(wr_win, wr_addr, 1'b1, OFS_P_CAUSE + CPU_STRIDE*c)),
            .ack_data(wr_data), .evt(edge_evt), .q(p_cause[c]));
         pcb_mask_reg #(.W(NUM_PINS)) u_emask (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && hit(wr_win, wr_addr, 1'b1, OFS_P_EMASK + CPU_STRIDE*c)),
            .d(wr_data), .q(p_emask[c]));
         pcb_mask_reg #(.W(NUM_PINS)) u_lmask (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && hit(wr_win, wr_addr, 1'b1, OFS_P_LMASK + CPU_STRIDE*c)),
            .d(wr_data), .q(p_lmask[c]));
      end else begin : g_off
         assign p_cause[c] = '0;
         assign p_emask[c] = '0;
         assign p_lmask[c] = '0;
      end
   end

   // ---------------- per-CPU source selection and summaries ----------------
   logic [NUM_PINS-1:0] s_cause [MAX_CPUS];
   logic [NUM_PINS-1:0] s_emask [MAX_CPUS];
   logic [NUM_PINS-1:0] s_lmask [MAX_CPUS];

   for (genvar c = 0; c < MAX_CPUS; c++) begin : g_cpu
      if (LAYOUT == LAYOUT_QUAD) begin : g_q
         assign s_cause[c] = p_cause[c];
         assign s_emask[c] = p_emask[c];
         assign s_lmask[c] = p_lmask[c];
      end else if (LAYOUT == LAYOUT_DUAL && c == 0) begin : g_d0
         assign s_cause[c] = g_cause;
         assign s_emask[c] = g_emask;
         assign s_lmask[c] = g_lmask;
      end else if (LAYOUT == LAYOUT_DUAL && c == 1) begin : g_d1
         assign s_cause[c] = g_cause;
         assign s_emask[c] = d_emask1;
         assign s_lmask[c] = d_lmask1;
      end else begin : g_none
         assign s_cause[c] = '0;
         assign s_emask[c] = '0;
         assign s_lmask[c] = '0;
      end

      pcb_summary #(.W(NUM_PINS), .GP(GROUP_PINS)) u_sum (
         .clk(clk), .rst_n(rst_n), .data_in(data_in),
         .lmask(s_lmask[c]), .cause(s_cause[c]), .emask(s_emask[c]),
         .grp(cpu_irq[c*GROUPS +: GROUPS]));
   end

   if (LAYOUT == LAYOUT_GLOBAL) begin : g_glob_only
      // R3
      cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq == '0);
   end

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      if (hit(rd_win, rd_addr, 1'b0, OFS_G_CAUSE)) rd_data = g_cause;
      if (hit(rd_win, rd_addr, 1'b0, OFS_G_EMASK)) rd_data = g_emask;
      if (hit(rd_win, rd_addr, 1'b0, OFS_G_LMASK)) rd_data = g_lmask;
      if (LAYOUT == LAYOUT_DUAL) begin
         if (hit(rd_win, rd_addr, 1'b0, OFS_D_EMASK1)) rd_data = d_emask1;
         if (hit(rd_win, rd_addr, 1'b0, OFS_D_LMASK1)) rd_data = d_lmask1;
      end
      if (LAYOUT == LAYOUT_QUAD) begin
         for (int n = 0; n < MAX_CPUS; n++) begin
            if (hit(rd_win, rd_addr, 1'b1, OFS_P_CAUSE + CPU_STRIDE*n)) rd_data = p_cause[n];
            if (hit(rd_win, rd_addr, 1'b1, OFS_P_EMASK + CPU_STRIDE*n)) rd_data = p_emask[n];
            if (hit(rd_win, rd_addr, 1'b1, OFS_P_LMASK + CPU_STRIDE*n)) rd_data = p_lmask[n];
         end
      end
   end
endmodule

// File: tb/tb_gpio_cpu_irq_bank.sv
module tb_gpio_cpu_irq_bank;
   import pcb_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [31:0] data_in, edge_evt, wr_data;
   logic        wr_en, wr_win, rd_win;
   logic [7:0]  wr_addr, rd_addr;

   logic [31:0] rd_q, rd_d, rd_g;
   logic [3:0]  gi_q, gi_d, gi_g;
   logic [15:0] irq_q, irq_d, irq_g;

   gpio_cpu_irq_bank #(.LAYOUT(LAYOUT_QUAD)) dut (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .edge_evt(edge_evt),
      .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_q),
      .glob_irq(gi_q), .cpu_irq(irq_q));

   gpio_cpu_irq_bank #(.LAYOUT(LAYOUT_DUAL)) dut_dual (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .edge_evt(edge_evt),
      .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_d),
      .glob_irq(gi_d), .cpu_irq(irq_d));

   gpio_cpu_irq_bank #(.LAYOUT(LAYOUT_GLOBAL)) dut_glob (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .edge_evt(edge_evt),
      .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_g),
      .glob_irq(gi_g), .cpu_irq(irq_g));

   // kinds: 0 quad rd, 1 quad cpu_irq, 2 quad glob_irq, 3 dual rd,
   //        4 dual cpu_irq, 5 global-layout rd, 6 global-layout cpu_irq,
   //        7 global-layout glob_irq
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.kind)
            0: act = rd_q;
            1: act = {16'h0, irq_q};
            2: act = {28'h0, gi_q};
            3: act = rd_d;
            4: act = {16'h0, irq_d};
            5: act = rd_g;
            6: act = {16'h0, irq_g};
            default: act = {28'h0, gi_g};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic chk(input int kind, input logic win, input logic [7:0] a,
                      input logic [31:0] exp, input string tag);
      item_t it;
      rd_win = win;
      rd_addr = a;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic win, input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_win = win; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(posedge clk); #1;
      edge_evt = v;
      @(posedge clk); #1;
      edge_evt = '0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; data_in = '0; edge_evt = '0; wr_data = '0;
      wr_en = 1'b0; wr_win = 1'b0; wr_addr = '0; rd_win = 1'b0; rd_addr = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 reset state
      chk(0, 1'b1, 8'h00, 32'h0, "R9 quad cause0");
      chk(0, 1'b1, 8'h2C, 32'h0, "R9 quad lmask3");
      chk(0, 1'b0, 8'h18, 32'h0, "R9 quad global emask");
      chk(1, 1'b0, 8'h00, 32'h0, "R9 quad cpu_irq");
      chk(2, 1'b0, 8'h00, 32'h0, "R9 quad glob_irq");
      chk(4, 1'b0, 8'h00, 32'h0, "R9 dual cpu_irq");

      // R1 per-CPU window write and read back
      wr(1'b1, 8'h14, 32'h0000_0100);
      chk(0, 1'b1, 8'h14, 32'h0000_0100, "R1 cpu1 edge mask");
      wr(1'b1, 8'h28, 32'h00FF_0000);
      chk(0, 1'b1, 8'h28, 32'h00FF_0000, "R1 cpu2 level mask");

      // R6 one event lands in every copy; R4 cpu1 group1 -> bit 5
      pulse(32'h0000_0100);
      chk(0, 1'b1, 8'h00, 32'h0000_0100, "R6 cause0");
      chk(0, 1'b1, 8'h04, 32'h0000_0100, "R6 cause1");
      chk(0, 1'b1, 8'h08, 32'h0000_0100, "R6 cause2");
      chk(0, 1'b1, 8'h0C, 32'h0000_0100, "R6 cause3");
      chk(0, 1'b0, 8'h14, 32'h0000_0100, "R6 global cause");
      chk(1, 1'b0, 8'h00, 32'h0000_0020, "R4 edge summary");

      // R5 R6 acknowledge cpu1 only
      wr(1'b1, 8'h04, 32'hFFFF_FEFF);
      chk(0, 1'b1, 8'h04, 32'h0, "R5 cause1 cleared");
      chk(0, 1'b1, 8'h00, 32'h0000_0100, "R6 cause0 untouched");
      chk(0, 1'b1, 8'h0C, 32'h0000_0100, "R6 cause3 untouched");
      chk(1, 1'b0, 8'h00, 32'h0, "R4 summary gone");

      // R5 ones preserved, zeros cleared
      pulse(32'h0000_0003);
      wr(1'b1, 8'h00, 32'h0000_0001);
      chk(0, 1'b1, 8'h00, 32'h0000_0001, "R5 cause0 partial ack");
      chk(0, 1'b1, 8'h08, 32'h0000_0103, "R6 cause2 accumulated");

      // R7 event and full ack of cause2 in the same cycle
      @(posedge clk); #1;
      edge_evt = 32'h0000_0004;
      wr_en = 1'b1; wr_win = 1'b1; wr_addr = 8'h08; wr_data = 32'h0;
      @(posedge clk); #1;
      edge_evt = '0; wr_en = 1'b0;
      chk(0, 1'b1, 8'h08, 32'h0000_0004, "R7 event survives ack");
      chk(0, 1'b1, 8'h0C, 32'h0000_0107, "R7 neighbour copy");

      // R4 level path, cpu2 group2 -> bit 10
      data_in = 32'h0001_0000;
      chk(1, 1'b0, 8'h00, 32'h0000_0400, "R4 level low pin");
      data_in = 32'h0080_0000;
      chk(1, 1'b0, 8'h00, 32'h0000_0400, "R4 level high pin");
      data_in = 32'h0100_0000;
      chk(1, 1'b0, 8'h00, 32'h0, "R4 level masked pin");
      data_in = '0;

      // R10 global set summary
      wr(1'b0, 8'h18, 32'h0000_0001);
      chk(0, 1'b0, 8'h18, 32'h0000_0001, "R10 global emask");
      chk(0, 1'b0, 8'h14, 32'h0000_0107, "R10 global cause");
      chk(2, 1'b0, 8'h00, 32'h1, "R10 quad glob_irq");

      // R8 undecoded addresses
      wr(1'b1, 8'h30, 32'hFFFF_FFFF);
      chk(0, 1'b1, 8'h30, 32'h0, "R8 win1 0x30");
      wr(1'b1, 8'h3C, 32'hFFFF_FFFF);
      chk(0, 1'b1, 8'h3C, 32'h0, "R8 win1 0x3C");
      chk(0, 1'b1, 8'h10, 32'h0, "R8 cpu0 emask unchanged");
      chk(1, 1'b0, 8'h00, 32'h0, "R8 cpu_irq unchanged");

      // R2 dual layout, R3 global layout, R8 quad
      wr(1'b0, 8'h30, 32'h0000_0004);
      chk(0, 1'b0, 8'h30, 32'h0, "R8 quad win0 0x30");
      chk(3, 1'b0, 8'h30, 32'h0000_0004, "R2 dual cpu1 emask");
      chk(3, 1'b1, 8'h04, 32'h0, "R2 dual no per-CPU window");
      chk(3, 1'b0, 8'h14, 32'h0000_0107, "R2 dual shared cause");
      chk(4, 1'b0, 8'h00, 32'h0000_0011, "R2 dual summaries");
      chk(5, 1'b0, 8'h30, 32'h0, "R3 global layout 0x30");
      chk(5, 1'b0, 8'h18, 32'h0000_0001, "R3 global layout emask");
      chk(6, 1'b0, 8'h00, 32'h0, "R3 global layout cpu_irq");
      chk(7, 1'b0, 8'h00, 32'h1, "R10 global layout glob_irq");

      // R5 R6 global ack leaves per-CPU copies alone
      wr(1'b0, 8'h14, 32'hFFFF_FFFE);
      chk(0, 1'b0, 8'h14, 32'h0000_0106, "R5 global ack");
      chk(2, 1'b0, 8'h00, 32'h0, "R10 glob_irq cleared");
      chk(0, 1'b1, 8'h0C, 32'h0000_0107, "R6 cause3 after global ack");
      chk(4, 1'b0, 8'h00, 32'h0000_0010, "R2 dual after shared ack");

      wait (sb.size() == 0);
      @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule